// File: doc/BRIEF.md
# Flash Dummy-Cycle Tracker

This block sits next to a serial NOR flash controller and passively watches its traffic: the opcode of each transaction, the bytes written toward the memory, the bytes returned from it, and a pulse that marks the end of each transaction. It keeps its own copies of the dummy-cycle field from the device's two configuration registers, one volatile and one non-volatile. It also tracks which copy the device is currently using. The controller reads the active count from the output and uses it to space fast-read commands.

Each data byte is counted within its transaction. Only the byte that carries the field, for an opcode that targets one of the configuration registers, is captured. The captured value is held as pending and is committed only when the transaction ends. A committed volatile write makes the volatile copy active. A committed reset-to-non-volatile command makes the non-volatile copy active again.

Top module: `dcyc_tracker`

## Requirements
- R1: While reset is high, and right after it is released, the output is 10. Both copies hold 10, and the non-volatile copy is the active one.
- R2: Opcode 0x81 with a write byte at index 0 whose upper nibble is n (1 to 14) sets the volatile copy to n and makes it active. The output shows n from the clock edge that samples the end-of-transaction pulse.
- R3: When a transaction with opcode 0x99 ends, the non-volatile copy becomes active again.
- R4: Opcode 0xB1 updates the non-volatile copy from the upper nibble of the write byte at index 1.
- R5: Opcode 0xB5 updates the non-volatile copy from the upper nibble of the read byte at index 1.
- R6: Opcode 0x85 updates the volatile copy from the upper nibble of the read byte at index 0.
- R7: A captured nibble of 0x0 or 0xF is stored as 10. The output is never 0 or 15.
- R8: The output changes only on the edge after the end-of-transaction pulse, or under reset. It never changes in the middle of a transaction.
- R9: Bytes at any index other than the one that carries the field do not affect either copy.
- R10: A byte counts only when its own strobe is high. A write byte is captured only for a write opcode, and a read byte only for a read opcode. Any other data on the buses has no effect.
- R11: Committing a new non-volatile value while the volatile copy is active leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| eot_i | input | 1 | One-cycle pulse marking the end of a transaction |
| cmd_i | input | 8 | Opcode, held from the start of a transaction until its first data byte |
| wr_vld_i | input | 1 | A byte is being written to the memory this cycle |
| wr_data_i | input | 8 | Byte written to the memory |
| rd_vld_i | input | 1 | A byte returned by the memory this cycle |
| rd_data_i | input | 8 | Byte returned by the memory |
| dummy_cycles_o | output | 4 | Active dummy-cycle count, 1 to 14 |

## Verification
A wrong active-copy selection shows on the output on the edge after the end-of-transaction pulse. A corrupted copy can stay hidden while the other copy is active. It only appears after a later 0x81 or 0x99 brings that copy forward, so the tests switch between the copies after every update. A wrong byte index or a wrong strobe gate appears as a wrong value one cycle after the end of the transaction. A missing commit gate appears as an output change in the middle of a transaction, which the tests sample directly.

// File: rtl/dcyc_pkg.sv
package dcyc_pkg;
   typedef enum logic {
      SRC_NV  = 1'b0,
      SRC_VOL = 1'b1
   } dc_src_e;

   localparam int unsigned NUM_SRC = 2;

   localparam logic [7:0] OPC_NV_WR_D  = 8'hB1;
   localparam logic [7:0] OPC_NV_RD_D  = 8'hB5;
   localparam logic [7:0] OPC_VOL_WR_D = 8'h81;
   localparam logic [7:0] OPC_VOL_RD_D = 8'h85;
   localparam logic [7:0] OPC_RST_NV_D = 8'h99;
endpackage

// File: rtl/dcyc_cmd_track.sv
module dcyc_cmd_track #(
   parameter int unsigned CMD_W = 8,
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             eot_i,
   input  logic             byte_i,
   input  logic [CMD_W-1:0] cmd_i,
   output logic [CMD_W-1:0] cmd_eff_o,
   output logic [CNT_W-1:0] idx_o
);
   localparam logic [CNT_W-1:0] IDX_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CMD_W-1:0] cmd_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         cmd_q <= '0;
      end else begin
         if (cnt_q == '0) cmd_q <= cmd_i;
         if (eot_i) begin
            cnt_q <= '0;
         end else if (byte_i && (cnt_q != IDX_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cmd_eff_o = (cnt_q == '0) ? cmd_i : cmd_q;
   assign idx_o     = cnt_q;
endmodule

// File: rtl/dcyc_shadow.sv
module dcyc_shadow #(
   parameter int unsigned CMD_W       = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned FIELD_W     = 4,
   parameter int unsigned CNT_W       = 2,
   parameter int unsigned BYTE_IDX    = 0,
   parameter int unsigned DEFAULT_VAL = 10,
   parameter logic [CMD_W-1:0] OPC_WR = 8'h81,
   parameter logic [CMD_W-1:0] OPC_RD = 8'h85
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               eot_i,
   input  logic [CMD_W-1:0]   cmd_eff_i,
   input  logic [CNT_W-1:0]   idx_i,
   input  logic               wr_vld_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic               rd_vld_i,
   input  logic [DATA_W-1:0]  rd_data_i,
   output logic [FIELD_W-1:0] val_o
);
   localparam logic [FIELD_W-1:0] DFLT    = FIELD_W'(DEFAULT_VAL);
   localparam logic [CNT_W-1:0]   IDX_HIT = CNT_W'(BYTE_IDX);
   localparam int unsigned        FLD_MSB = DATA_W - 1;

   logic               hit_wr, hit_rd, hit;
   logic [FIELD_W-1:0] raw_fld, dec_fld, nxt_val;
   logic [FIELD_W-1:0] pend_q, val_q;
   logic               pend_vld_q;

   assign hit_wr = wr_vld_i && (cmd_eff_i == OPC_WR) && (idx_i == IDX_HIT);
   assign hit_rd = rd_vld_i && (cmd_eff_i == OPC_RD) && (idx_i == IDX_HIT);
   assign hit    = hit_wr || hit_rd;

   always_comb begin
      raw_fld = hit_wr ? wr_data_i[FLD_MSB -: FIELD_W] : rd_data_i[FLD_MSB -: FIELD_W];
      if ((raw_fld == '0) || (raw_fld == '1)) dec_fld = DFLT;
      else                                    dec_fld = raw_fld;
      nxt_val = hit ? dec_fld : pend_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_q     <= DFLT;
         pend_vld_q <= 1'b0;
         val_q      <= DFLT;
      end else if (eot_i) begin
         if (hit || pend_vld_q) val_q <= nxt_val;
         pend_vld_q <= 1'b0;
      end else if (hit) begin
         pend_q     <= dec_fld;
         pend_vld_q <= 1'b1;
      end
   end

   assign val_o = val_q;
endmodule

// File: rtl/dcyc_tracker.sv
module dcyc_tracker
   import dcyc_pkg::*;
#(
   parameter int unsigned CMD_W        = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned FIELD_W      = 4,
   parameter int unsigned CNT_W        = 2,
   parameter int unsigned DEFAULT_VAL  = 10,
   parameter int unsigned NV_BYTE_IDX  = 1,
   parameter int unsigned VOL_BYTE_IDX = 0,
   parameter logic [CMD_W-1:0] OPC_NV_WR  = OPC_NV_WR_D,
   parameter logic [CMD_W-1:0] OPC_NV_RD  = OPC_NV_RD_D,
   parameter logic [CMD_W-1:0] OPC_VOL_WR = OPC_VOL_WR_D,
   parameter logic [CMD_W-1:0] OPC_VOL_RD = OPC_VOL_RD_D,
   parameter logic [CMD_W-1:0] OPC_RST_NV = OPC_RST_NV_D
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               eot_i,
   input  logic [CMD_W-1:0]   cmd_i,
   input  logic               wr_vld_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic               rd_vld_i,
   input  logic [DATA_W-1:0]  rd_data_i,
   output logic [FIELD_W-1:0] dummy_cycles_o
);
   localparam int unsigned FIELD_MAX = (1 << FIELD_W) - 1;
   localparam int unsigned IDX_LIM   = 1 << CNT_W;

   if (FIELD_W > DATA_W) begin : g_bad_field
      $error("dcyc_tracker: FIELD_W must not exceed DATA_W");
   end
   if ((DEFAULT_VAL == 0) || (DEFAULT_VAL >= FIELD_MAX)) begin : g_bad_dflt
      $error("dcyc_tracker: DEFAULT_VAL must be a non-reserved field value");
   end
   if ((NV_BYTE_IDX >= IDX_LIM - 1) || (VOL_BYTE_IDX >= IDX_LIM - 1)) begin : g_bad_idx
      $error("dcyc_tracker: CNT_W too small for the field byte index");
   end

   logic [CMD_W-1:0]   cmd_eff;
   logic [CNT_W-1:0]   byte_idx;
   logic [FIELD_W-1:0] shadow_val [NUM_SRC];
   dc_src_e            sel_q;

   dcyc_cmd_track #(
      .CMD_W (CMD_W),
      .CNT_W (CNT_W)
   ) u_cmd (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .eot_i     (eot_i),
      .byte_i    (wr_vld_i | rd_vld_i),
      .cmd_i     (cmd_i),
      .cmd_eff_o (cmd_eff),
      .idx_o     (byte_idx)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      localparam bit IS_VOL = (g == int'(SRC_VOL));
      dcyc_shadow #(
         .CMD_W       (CMD_W),
         .DATA_W      (DATA_W),
         .FIELD_W     (FIELD_W),
         .CNT_W       (CNT_W),
         .BYTE_IDX    (IS_VOL ? VOL_BYTE_IDX : NV_BYTE_IDX),
         .DEFAULT_VAL (DEFAULT_VAL),
         .OPC_WR      (IS_VOL ? OPC_VOL_WR : OPC_NV_WR),
         .OPC_RD      (IS_VOL ? OPC_VOL_RD : OPC_NV_RD)
      ) u_shadow (
         .clk_i     (clk_i),
         .rst_i     (rst_i),
         .eot_i     (eot_i),
         .cmd_eff_i (cmd_eff),
         .idx_i     (byte_idx),
         .wr_vld_i  (wr_vld_i),
         .wr_data_i (wr_data_i),
         .rd_vld_i  (rd_vld_i),
         .rd_data_i (rd_data_i),
         .val_o     (shadow_val[g])
      );
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sel_q <= SRC_NV;
      end else if (eot_i) begin
         if (cmd_eff == OPC_VOL_WR)      sel_q <= SRC_VOL;
         else if (cmd_eff == OPC_RST_NV) sel_q <= SRC_NV;
      end
   end

   assign dummy_cycles_o = shadow_val[sel_q];
endmodule

// File: rtl/dcyc_tracker_chk.sv
module dcyc_tracker_chk #(
   parameter int unsigned CMD_W       = 8,
   parameter int unsigned FIELD_W     = 4,
   parameter int unsigned DEFAULT_VAL = 10,
   parameter logic [CMD_W-1:0] OPC_VOL_WR = 8'h81,
   parameter logic [CMD_W-1:0] OPC_RST_NV = 8'h99
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic               eot_i,
   input logic [CMD_W-1:0]   cmd_eff,
   input logic               sel_vol,
   input logic [FIELD_W-1:0] dummy_cycles_o
);
   logic armed_q = 1'b0;
   always_ff @(posedge clk_i) armed_q <= armed_q | rst_i;

   a_r1_reset_default: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
      $past(rst_i) |-> (dummy_cycles_o == FIELD_W'(DEFAULT_VAL)) && !sel_vol);

   a_r8_hold_mid_txn: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
      (!$past(eot_i) && !$past(rst_i)) |-> $stable(dummy_cycles_o));

   a_r7_no_reserved: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
      (dummy_cycles_o != '0) && (dummy_cycles_o != '1));

   a_r2_vol_selected: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
      ($past(eot_i) && !$past(rst_i) && ($past(cmd_eff) == OPC_VOL_WR)) |-> sel_vol);

   a_r3_nv_selected: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
      ($past(eot_i) && !$past(rst_i) && ($past(cmd_eff) == OPC_RST_NV)) |-> !sel_vol);
endmodule

bind dcyc_tracker dcyc_tracker_chk #(
   .CMD_W       (CMD_W),
   .FIELD_W     (FIELD_W),
   .DEFAULT_VAL (DEFAULT_VAL),
   .OPC_VOL_WR  (OPC_VOL_WR),
   .OPC_RST_NV  (OPC_RST_NV)
) u_chk (
   .clk_i          (clk_i),
   .rst_i          (rst_i),
   .eot_i          (eot_i),
   .cmd_eff        (cmd_eff),
   .sel_vol        (sel_q == dcyc_pkg::SRC_VOL),
   .dummy_cycles_o (dummy_cycles_o)
);

// File: tb/dcyc_tracker_tb.sv
module dcyc_tracker_tb_top;
   logic       clk = 1'b0;
   logic       rst_i = 1'b1;
   logic       eot_i = 1'b0;
   logic [7:0] cmd_i = 8'h00;
   logic       wr_vld_i = 1'b0;
   logic [7:0] wr_data_i = 8'h00;
   logic       rd_vld_i = 1'b0;
   logic [7:0] rd_data_i = 8'h00;
   logic [3:0] dummy_cycles_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dcyc_tracker dut_i (
      .clk_i          (clk),
      .rst_i          (rst_i),
      .eot_i          (eot_i),
      .cmd_i          (cmd_i),
      .wr_vld_i       (wr_vld_i),
      .wr_data_i      (wr_data_i),
      .rd_vld_i       (rd_vld_i),
      .rd_data_i      (rd_data_i),
      .dummy_cycles_o (dummy_cycles_o)
   );

   task automatic check(input string req, input logic [3:0] exp);
      n_chk++;
      if (dummy_cycles_o !== exp) begin
         n_bad++;
         $display("FAIL %s: dummy_cycles_o actual %0d expected %0d", req, dummy_cycles_o, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_i = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", 4'd10);
      rst_i = 1'b0;
      @(negedge clk);
      check("R1", 4'd10);
   endtask

   task automatic start(input logic [7:0] c);
      @(negedge clk) cmd_i = c;
   endtask

   task automatic wbyte(input logic [7:0] d);
      @(negedge clk) begin wr_vld_i = 1'b1; wr_data_i = d; end
      @(negedge clk) wr_vld_i = 1'b0;
   endtask

   task automatic rbyte(input logic [7:0] d);
      @(negedge clk) begin rd_vld_i = 1'b1; rd_data_i = d; end
      @(negedge clk) rd_vld_i = 1'b0;
   endtask

   task automatic finish_txn();
      @(negedge clk) eot_i = 1'b1;
      @(negedge clk) eot_i = 1'b0;
   endtask

   task automatic t_vol_write();
      start(8'h81); wbyte(8'h3A);
      check("R8 mid 0x81", 4'd10);
      finish_txn();
      check("R2 vol write", 4'd3);
   endtask

   task automatic t_vol_read();
      start(8'h85); rbyte(8'h7E);
      check("R8 mid 0x85", 4'd3);
      finish_txn();
      check("R6 vol read", 4'd7);
   endtask

   task automatic t_nv_write_hidden();
      start(8'hB1); wbyte(8'h55); wbyte(8'hC0);
      finish_txn();
      check("R11 nv write hidden", 4'd7);
      start(8'h99); finish_txn();
      check("R3 R4 nv restore", 4'd12);
   endtask

   task automatic t_nv_read();
      start(8'hB5); rbyte(8'h2A); rbyte(8'h60); rbyte(8'h90);
      check("R8 mid 0xB5", 4'd12);
      finish_txn();
      check("R5 R9 nv read", 4'd6);
   endtask

   task automatic t_reserved();
      start(8'hB1); wbyte(8'h11); wbyte(8'hF3);
      finish_txn();
      check("R7 nv 0xF", 4'd10);
      start(8'h81); wbyte(8'hD0); finish_txn();
      check("R2 vol 13", 4'd13);
      start(8'h81); wbyte(8'h0A); finish_txn();
      check("R7 vol 0x0", 4'd10);
   endtask

   task automatic t_gating();
      start(8'h81); wbyte(8'h90); wbyte(8'h20);
      finish_txn();
      check("R9 vol second byte", 4'd9);
      start(8'h81); rbyte(8'h40);
      @(negedge clk) wr_data_i = 8'h20;
      @(negedge clk) rd_data_i = 8'h50;
      finish_txn();
      check("R10 strobe gating", 4'd9);
      start(8'h99); finish_txn();
      check("R3 back to nv", 4'd10);
   endtask

   task automatic t_reset_mid();
      start(8'h81); wbyte(8'h40); finish_txn();
      check("R2 vol 4", 4'd4);
      do_reset();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 4'd10);
      rst_i = 1'b0;
      @(negedge clk);
      check("R1", 4'd10);
      t_vol_write();
      t_vol_read();
      t_nv_write_hidden();
      t_nv_read();
      t_reserved();
      t_gating();
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run actual hung expected complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule